// File: doc/BRIEF.md
# Modem Status Change Tracker

This block holds an 8-bit modem status register for a serial port. The upper nibble reports four line states: carrier detect, ring indicator, data set ready and clear to send. The lower nibble holds change flags. The line states come from one of two sources. In loopback mode they are taken from the port's own modem control outputs. In normal mode they come from external pins, passed through a synchroniser.

Every cycle the block compares the incoming line states with the stored ones and sets sticky change flags. A flag set in this way raises a modem-status request. When the host reads the register, it receives the full value. The flags and the request are then cleared, but a change that arrives in the same cycle as the read is kept.

The host can also load the register directly. The block keeps the modem control register, because it needs that register for loopback. It gives one pulse to an attached device each time the request-to-send control bit is switched on.

Top module: `msr_tracker`

## Requirements
- R1: After reset, `stat_rdata` is 0x00, `msi_req` is 0 and `rts_pulse` is 0.
- R2: With modem control bit 4 set (loopback), a modem control write maps its bits onto the status at the same clock edge: control bit 3 to status bit 7, bit 2 to status bit 6, bit 0 to status bit 5, and bit 1 to status bit 4.
- R3: A change of status bit 4 sets flag bit 0. A change of bit 5 sets flag bit 1. A change of bit 7 sets flag bit 3. Each of these flags is set for a change in either direction.
- R4: Flag bit 2 is set only when status bit 6 (ring indicator) falls from 1 to 0. A rising ring indicator sets no flag.
- R5: A read (`stat_rd` high for one cycle) returns the whole register on `stat_rdata` during that cycle. At the next edge the read clears bits 3:0 and `msi_req`, and bits 7:4 stay as they are.
- R6: A line change in the same cycle as a read sets its flag and `msi_req` after that edge. The read does not lose it.
- R7: A status write (`stat_wr`) loads `stat_wdata` into the register at the next edge. After the write, `msi_req` is 1 exactly when bits 3:0 of the written value are nonzero. In every state, `msi_req` equals the OR of status bits 3:0.
- R8: A modem control write that sets bit 1 while the stored bit 1 is 0 drives `rts_pulse` high for exactly the one cycle after the write. Any other write gives no pulse.
- R9: With loopback off, status bits 7:4 follow `line_in[3:0]` (carrier detect, ring, data set ready, clear to send). A change on `line_in` shows up after SYNC_STAGES+1 clock edges, and the same flag rules apply.
- R10: Change flags are sticky. They collect several changes until a read clears them.
- R11: When a status write and a read fall in the same cycle, the write wins. The register takes the written value and is not cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mctl_wr | input | 1 | Modem control register write strobe |
| mctl_wdata | input | 8 | Modem control write data (bit 4 selects loopback) |
| stat_wr | input | 1 | Status register write strobe |
| stat_wdata | input | 8 | Status register write data |
| stat_rd | input | 1 | Status register read strobe (clears flags) |
| stat_rdata | output | 8 | Current status register value |
| line_in | input | 4 | External lines {carrier, ring, dsr, cts}, asynchronous |
| msi_req | output | 1 | Modem-status request pending |
| rts_pulse | output | 1 | One-cycle notice of request-to-send switching on |

## Verification
A line change and a host read can fall in the same cycle. In that case the flag must be set and the request raised, not lost to the read. The bench provokes this in loopback: it asserts `stat_rd` in the same cycle as a modem control write that switches clear-to-send. It checks that the read returns the old value and that, after the edge, flag bit 0 and `msi_req` are set. The bench also issues a status write and a read together, and checks that the written value survives the read.

// File: rtl/msr_pkg.sv
package msr_pkg;
    localparam int LINES   = 4;
    localparam int REG_W   = 8;
    localparam int LOOP_B  = 4;   // modem control loopback enable
    localparam int RTS_B   = 1;   // modem control request-to-send
    // line vector index: 0=cts, 1=dsr, 2=ring, 3=carrier
    localparam int RING_I  = 2;

    typedef struct packed {
        logic [REG_W-1:0] stat;
        logic [REG_W-1:0] mctl;
        logic             pend;
        logic             rts_pls;
    } msr_state_t;
endpackage

// File: rtl/msr_line_sync.sv
module msr_line_sync #(
    parameter int W      = 4,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] sync_out
);
    logic [W-1:0] chain_q [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) chain_q[i] <= '0;
        end else begin
            chain_q[0] <= async_in;
            for (int i = 1; i < STAGES; i++) chain_q[i] <= chain_q[i-1];
        end
    end

    assign sync_out = chain_q[STAGES-1];
endmodule

// File: rtl/msr_line_select.sv
module msr_line_select (
    input  logic       loop_en,
    input  logic [3:0] mctl_lo,
    input  logic [3:0] ext_lines,
    output logic [3:0] lines
);
    logic [3:0] looped;

    // carrier <- out2, ring <- out1, dsr <- dtr, cts <- rts
    assign looped = {mctl_lo[3], mctl_lo[2], mctl_lo[0], mctl_lo[1]};
    assign lines  = loop_en ? looped : ext_lines;
endmodule

// File: rtl/msr_delta.sv
module msr_delta #(
    parameter int W      = 4,
    parameter int FALL_I = 2
) (
    input  logic [W-1:0] old_lines,
    input  logic [W-1:0] new_lines,
    output logic [W-1:0] flags
);
    for (genvar g = 0; g < W; g++) begin : g_bit
        if (g == FALL_I) begin : g_fall
            assign flags[g] = old_lines[g] & ~new_lines[g];
        end else begin : g_any
            assign flags[g] = old_lines[g] ^ new_lines[g];
        end
    end
endmodule

// File: rtl/msr_tracker.sv
module msr_tracker
    import msr_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       mctl_wr,
    input  logic [7:0] mctl_wdata,
    input  logic       stat_wr,
    input  logic [7:0] stat_wdata,
    input  logic       stat_rd,
    output logic [7:0] stat_rdata,
    input  logic [3:0] line_in,
    output logic       msi_req,
    output logic       rts_pulse
);
    localparam int FLAG_LO = 0;
    localparam int LINE_LO = LINES;

    msr_state_t       st_q, st_d;
    logic [REG_W-1:0] mctl_nx;
    logic [LINES-1:0] ext_sync;
    logic [LINES-1:0] lines_nx;
    logic [LINES-1:0] delta;

    assign mctl_nx = mctl_wr ? mctl_wdata : st_q.mctl;

    msr_line_sync #(.W(LINES), .STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (line_in),
        .sync_out (ext_sync)
    );

    msr_line_select u_sel (
        .loop_en   (mctl_nx[LOOP_B]),
        .mctl_lo   (mctl_nx[3:0]),
        .ext_lines (ext_sync),
        .lines     (lines_nx)
    );

    msr_delta #(.W(LINES), .FALL_I(RING_I)) u_delta (
        .old_lines (st_q.stat[LINE_LO +: LINES]),
        .new_lines (lines_nx),
        .flags     (delta)
    );

    always_comb begin
        logic [LINES-1:0] kept;
        st_d         = st_q;
        st_d.mctl    = mctl_nx;
        st_d.rts_pls = mctl_wr & mctl_wdata[RTS_B] & ~st_q.mctl[RTS_B];
        kept         = stat_rd ? '0 : st_q.stat[FLAG_LO +: LINES];
        if (stat_wr) begin
            st_d.stat = stat_wdata;
            st_d.pend = |stat_wdata[FLAG_LO +: LINES];
        end else begin
            st_d.stat[LINE_LO +: LINES] = lines_nx;
            st_d.stat[FLAG_LO +: LINES] = kept | delta;
            st_d.pend = (st_q.pend & ~stat_rd) | (|delta);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign stat_rdata = st_q.stat;
    assign msi_req    = st_q.pend;
    assign rts_pulse  = st_q.rts_pls;
endmodule

// File: rtl/msr_tracker_chk.sv
module msr_tracker_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       mctl_wr,
    input logic [7:0] mctl_wdata,
    input logic       stat_wr,
    input logic [7:0] stat_wdata,
    input logic       stat_rd,
    input logic [7:0] stat_rdata,
    input logic       msi_req,
    input logic       rts_pulse
);
    p_write_loads_r7: assert property (@(posedge clk) disable iff (!rst_n)
        stat_wr |=> stat_rdata == $past(stat_wdata));

    p_req_matches_flags_r7: assert property (@(posedge clk) disable iff (!rst_n)
        msi_req == (|stat_rdata[3:0]));

    p_flags_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!stat_rd && !stat_wr) |=>
            ((stat_rdata[3:0] & $past(stat_rdata[3:0])) == $past(stat_rdata[3:0])));

    p_cts_flag_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_rd && !stat_wr) |=> stat_rdata[0] == (stat_rdata[4] != $past(stat_rdata[4])));

    p_ring_fall_only_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_rd && !stat_wr) |=> stat_rdata[2] == ($past(stat_rdata[6]) && !stat_rdata[6]));

    p_rts_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rts_pulse |=> !rts_pulse);

    p_rts_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rts_pulse) |-> $past(mctl_wr && mctl_wdata[1]));
endmodule

bind msr_tracker msr_tracker_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .mctl_wr    (mctl_wr),
    .mctl_wdata (mctl_wdata),
    .stat_wr    (stat_wr),
    .stat_wdata (stat_wdata),
    .stat_rd    (stat_rd),
    .stat_rdata (stat_rdata),
    .msi_req    (msi_req),
    .rts_pulse  (rts_pulse)
);

// File: tb/msr_tracker_bench.sv
`timescale 1ns/1ps
module msr_tracker_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mctl_wr = 1'b0;
    logic [7:0] mctl_wdata = '0;
    logic       stat_wr = 1'b0;
    logic [7:0] stat_wdata = '0;
    logic       stat_rd = 1'b0;
    logic [7:0] stat_rdata;
    logic [3:0] line_in = '0;
    logic       msi_req;
    logic       rts_pulse;
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    msr_tracker u_msr_tracker (
        .clk(clk), .rst_n(rst_n), .mctl_wr(mctl_wr), .mctl_wdata(mctl_wdata),
        .stat_wr(stat_wr), .stat_wdata(stat_wdata), .stat_rd(stat_rd),
        .stat_rdata(stat_rdata), .line_in(line_in), .msi_req(msi_req),
        .rts_pulse(rts_pulse)
    );

    task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string req);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic wr_mctl(input logic [7:0] v, input bit pulse, input logic [7:0] exp, input string req);
        @(negedge clk); mctl_wr = 1'b1; mctl_wdata = v;
        @(negedge clk); mctl_wr = 1'b0;
        chk(stat_rdata, exp, req);
        chk({7'd0, msi_req}, {7'd0, |exp[3:0]}, {req, " req"});
        chk({7'd0, rts_pulse}, {7'd0, pulse}, "R8 pulse");
        @(negedge clk);
        chk({7'd0, rts_pulse}, 8'd0, "R8 pulse width");
    endtask

    task automatic rd_stat(input logic [7:0] ret, input logic [7:0] after, input string req);
        @(negedge clk); stat_rd = 1'b1;
        chk(stat_rdata, ret, {req, " read value"});
        @(negedge clk); stat_rd = 1'b0;
        chk(stat_rdata, after, {req, " after read"});
        chk({7'd0, msi_req}, {7'd0, |after[3:0]}, {req, " req after read"});
    endtask

    task automatic t_reset;
        chk(stat_rdata, 8'h00, "R1 status");
        chk({7'd0, msi_req}, 8'd0, "R1 req");
        chk({7'd0, rts_pulse}, 8'd0, "R1 pulse");
    endtask

    task automatic t_loop_map;
        wr_mctl(8'h18, 1'b0, 8'h88, "R2 carrier");
        rd_stat(8'h88, 8'h80, "R5");
        wr_mctl(8'h15, 1'b0, 8'h6A, "R2 R3 R4 ring rise");
        rd_stat(8'h6A, 8'h60, "R5");
        wr_mctl(8'h11, 1'b0, 8'h24, "R4 ring fall");
        rd_stat(8'h24, 8'h20, "R5");
    endtask

    task automatic t_rts_sticky;
        wr_mctl(8'h12, 1'b1, 8'h13, "R8 R3 rts on");
        wr_mctl(8'h12, 1'b0, 8'h13, "R8 no repeat");
        rd_stat(8'h13, 8'h10, "R5");
        wr_mctl(8'h10, 1'b0, 8'h01, "R3 cts fall");
        rd_stat(8'h01, 8'h00, "R5");
        wr_mctl(8'h18, 1'b0, 8'h88, "R10 first");
        wr_mctl(8'h19, 1'b0, 8'hAA, "R10 accumulate");
        rd_stat(8'hAA, 8'hA0, "R10");
    endtask

    task automatic t_read_collide;
        @(negedge clk); stat_rd = 1'b1; mctl_wr = 1'b1; mctl_wdata = 8'h1B;
        chk(stat_rdata, 8'hA0, "R6 read value");
        @(negedge clk); stat_rd = 1'b0; mctl_wr = 1'b0;
        chk(stat_rdata, 8'hB1, "R6 change kept");
        chk({7'd0, msi_req}, 8'd1, "R6 req kept");
        chk({7'd0, rts_pulse}, 8'd1, "R8 pulse on collide");
        rd_stat(8'hB1, 8'hB0, "R5");
    endtask

    task automatic t_host_write;
        @(negedge clk); stat_wr = 1'b1; stat_wdata = 8'hB0;
        @(negedge clk); stat_wr = 1'b0;
        chk(stat_rdata, 8'hB0, "R7 load clean");
        chk({7'd0, msi_req}, 8'd0, "R7 no req");
        @(negedge clk); stat_wr = 1'b1; stat_wdata = 8'hB4;
        @(negedge clk); stat_wr = 1'b0;
        chk(stat_rdata, 8'hB4, "R7 load flag");
        chk({7'd0, msi_req}, 8'd1, "R7 req");
        rd_stat(8'hB4, 8'hB0, "R5");
        @(negedge clk); stat_wr = 1'b1; stat_wdata = 8'hB2; stat_rd = 1'b1;
        @(negedge clk); stat_wr = 1'b0; stat_rd = 1'b0;
        chk(stat_rdata, 8'hB2, "R11 write wins");
        chk({7'd0, msi_req}, 8'd1, "R11 req");
        rd_stat(8'hB2, 8'hB0, "R5");
        @(negedge clk); stat_wr = 1'b1; stat_wdata = 8'h30;
        @(negedge clk); stat_wr = 1'b0;
        chk(stat_rdata, 8'h30, "R7 loaded");
        chk({7'd0, msi_req}, 8'd0, "R7 no req");
        @(negedge clk);
        chk(stat_rdata, 8'hB8, "R3 tracked after load");
        rd_stat(8'hB8, 8'hB0, "R5");
    endtask

    task automatic t_external;
        wr_mctl(8'h00, 1'b0, 8'h0B, "R9 leave loop");
        rd_stat(8'h0B, 8'h00, "R5");
        @(negedge clk); line_in = 4'b0100;
        @(negedge clk); @(negedge clk);
        chk(stat_rdata, 8'h00, "R9 not yet");
        @(negedge clk);
        chk(stat_rdata, 8'h40, "R9 R4 ring rise");
        @(negedge clk); line_in = 4'b0000;
        repeat (3) @(negedge clk);
        chk(stat_rdata, 8'h04, "R9 R4 ring fall");
        @(negedge clk); line_in = 4'b0001;
        repeat (3) @(negedge clk);
        chk(stat_rdata, 8'h15, "R9 R10 cts");
        rd_stat(8'h15, 8'h10, "R5");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset;
        rst_n = 1'b1;
        @(negedge clk);
        t_reset;
        t_loop_map;
        t_rts_sticky;
        t_read_collide;
        t_host_write;
        t_external;
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule